// File: doc/BRIEF.md
# Motor PWM Fault Shutdown Unit

This unit sits between the PWM generator of a motor-control timer and the output pins. It watches four fault sources: an external fault pin, a clock-failure flag, a comparator-trip flag and a software strobe. When a fault is recognised, it drives every PWM channel to a programmable safe level. The external pin first passes through a synchronizer. It then passes through a polarity selector and an optional consecutive-sample filter, which runs from a programmable sample strobe.

A fault clears an output-run latch. Software sets the latch again once the fault has gone away. A sticky fault flag records each fault, and an interrupt request follows that flag when the interrupt enable is set. The software strobe always causes a fault. The three hardware sources act only when the fault enable is set.

Top module: `mbrk_top`

## Requirements
- R1: `pwm_out[i]` equals `pwm_in[i]` while the run latch is set and no fault event is present. Otherwise `pwm_out[i]` equals `idle_lvl[i]`. The output is forced in the same cycle as the event.
- R2: `clk_fail` high causes a fault event when `brk_en` is 1. It has no effect when `brk_en` is 0.
- R3: `cmp_trip` high causes a fault event when `brk_en` is 1. It has no effect when `brk_en` is 0.
- R4: `brk_pin` passes through a two-stage synchronizer. With the filter bypassed, a pin change drives the outputs after the second rising clock edge.
- R5: With `brk_pol`=0 the pin is active high, and with `brk_pol`=1 it is active low. Writing `brk_en` and `brk_pol` in the same cycle gives no event while the pin is inactive under the new polarity.
- R6: A `sw_brk` pulse causes a fault event even when `brk_en` is 0.
- R7: A nonzero `flt_sel` of 1 to 7 selects N = 2, 4, 6, 8, 10, 12 or 16. `flt_sel`=0 bypasses the filter. The filtered level changes only after N consecutive samples differ from it, so shorter pulses are rejected.
- R8: The filter samples on a strobe that fires once every `samp_div`+1 clock cycles.
- R9: A fault event clears the run latch (`moe`) at the next edge, and the latch stays clear after the source goes away. A `moe_set` pulse sets it again, but it is ignored in any cycle with a fault event.
- R10: `brk_flag` sets on the edge after a fault event and holds until a `flag_clr` pulse. An event and a clear in the same cycle leave the flag set.
- R11: `brk_irq` is high only when `brk_flag` and `irq_en` are both high.
- R12: After reset, `moe`=0, `brk_flag`=0 and `pwm_out`=`idle_lvl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| brk_pin | input | 1 | External fault pin (asynchronous) |
| clk_fail | input | 1 | Clock-failure detection flag |
| cmp_trip | input | 1 | Comparator trip flag |
| sw_brk | input | 1 | Software fault strobe |
| brk_en | input | 1 | Enable for the hardware fault sources |
| brk_pol | input | 1 | Pin polarity: 0 active high, 1 active low |
| flt_sel | input | 3 | Filter length select, 0 = bypass |
| samp_div | input | DIV_W | Sample strobe divider (period = value+1) |
| irq_en | input | 1 | Interrupt enable |
| moe_set | input | 1 | Pulse that sets the run latch |
| flag_clr | input | 1 | Write-one-to-clear pulse for the fault flag |
| idle_lvl | input | NCH | Safe level for each channel |
| pwm_in | input | NCH | Raw PWM channel values |
| pwm_out | output | NCH | Gated PWM channel values |
| brk_flag | output | 1 | Sticky fault flag |
| brk_irq | output | 1 | Fault interrupt request |
| moe | output | 1 | Run latch state |

## Verification
The direct sources (`clk_fail`, `cmp_trip`, `sw_brk`) force `pwm_out` in the cycle they are applied. `moe` and `brk_flag` change one edge later. The pin adds two edges of synchronizer delay. With a filter of length N and a sample strobe on every clock, the pin reaches the outputs N further edges after that. The bench drives inputs just after a rising edge and queues each expected value for a specific cycle. A monitor compares the queued values at the falling edge of that cycle. Each filter case checks the cycle before the due cycle as well as the due cycle, and glitch pulses one sample shorter than N must leave the outputs untouched.

// File: rtl/mbrk_pkg.sv
package mbrk_pkg;

    localparam int FSEL_W = 3;
    localparam int FCNT_W = 5;

    typedef enum logic {
        OUT_SAFE = 1'b0,
        OUT_RUN  = 1'b1
    } out_state_t;

    typedef struct packed {
        logic pin;
        logic clk_fail;
        logic cmp;
        logic sw;
    } brk_src_t;

    // Required consecutive-sample count for a filter select code.
    function automatic logic [FCNT_W-1:0] flt_len(input logic [FSEL_W-1:0] sel);
        if (sel == 3'd7)
            return 5'd16;
        return {1'b0, sel, 1'b0};
    endfunction

endpackage

// File: rtl/mbrk_sampler.sv
module mbrk_sampler #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             strobe
);
    logic [DIV_W-1:0] cnt;

    assign strobe = (cnt >= div);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (strobe)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/mbrk_sync.sv
module mbrk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mbrk_filter.sv
module mbrk_filter
    import mbrk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic              lvl,
    input  logic [FSEL_W-1:0] sel,
    output logic              filt
);
    logic [FCNT_W-1:0] cnt;
    logic [FCNT_W-1:0] need;
    logic              held;
    logic              bypass;

    assign need   = flt_len(sel);
    assign bypass = (sel == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= 1'b0;
            cnt  <= '0;
        end else if (bypass) begin
            held <= lvl;
            cnt  <= '0;
        end else if (strobe) begin
            if (lvl == held) begin
                cnt <= '0;
            end else if (cnt + 1'b1 == need) begin
                held <= lvl;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign filt = bypass ? lvl : held;
endmodule

// File: rtl/mbrk_ctl.sv
module mbrk_ctl
    import mbrk_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           evt,
    input  logic           moe_set,
    input  logic           flag_clr,
    input  logic           irq_en,
    input  logic [NCH-1:0] idle_lvl,
    input  logic [NCH-1:0] pwm_in,
    output logic [NCH-1:0] pwm_out,
    output logic           flag,
    output logic           irq,
    output logic           run
);
    out_state_t st;
    logic       pass;

    always_ff @(posedge clk) begin
        if (rst)
            st <= OUT_SAFE;
        else if (evt)
            st <= OUT_SAFE;
        else if (moe_set)
            st <= OUT_RUN;
    end

    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (evt)
            flag <= 1'b1;
        else if (flag_clr)
            flag <= 1'b0;
    end

    assign pass = (st == OUT_RUN) && !evt;
    assign run  = (st == OUT_RUN);
    assign irq  = flag & irq_en;

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            assign pwm_out[i] = pass ? pwm_in[i] : idle_lvl[i];
        end
    endgenerate
endmodule

// File: rtl/mbrk_top.sv
module mbrk_top
    import mbrk_pkg::*;
#(
    parameter int NCH         = 4,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              brk_pin,
    input  logic              clk_fail,
    input  logic              cmp_trip,
    input  logic              sw_brk,
    input  logic              brk_en,
    input  logic              brk_pol,
    input  logic [FSEL_W-1:0] flt_sel,
    input  logic [DIV_W-1:0]  samp_div,
    input  logic              irq_en,
    input  logic              moe_set,
    input  logic              flag_clr,
    input  logic [NCH-1:0]    idle_lvl,
    input  logic [NCH-1:0]    pwm_in,
    output logic [NCH-1:0]    pwm_out,
    output logic              brk_flag,
    output logic              brk_irq,
    output logic              moe
);
    logic     strobe;
    logic     pin_s;
    logic     pin_act;
    brk_src_t src;
    logic     evt;

    mbrk_sampler #(.DIV_W(DIV_W)) u_samp (
        .clk    (clk),
        .rst    (rst),
        .div    (samp_div),
        .strobe (strobe)
    );

    mbrk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (brk_pin),
        .q   (pin_s)
    );

    mbrk_filter u_filt (
        .clk    (clk),
        .rst    (rst),
        .strobe (strobe),
        .lvl    (pin_s ^ brk_pol),
        .sel    (flt_sel),
        .filt   (pin_act)
    );

    always_comb begin
        src.pin      = brk_en & pin_act;
        src.clk_fail = brk_en & clk_fail;
        src.cmp      = brk_en & cmp_trip;
        src.sw       = sw_brk;
    end

    assign evt = |src;

    mbrk_ctl #(.NCH(NCH)) u_ctl (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .moe_set  (moe_set),
        .flag_clr (flag_clr),
        .irq_en   (irq_en),
        .idle_lvl (idle_lvl),
        .pwm_in   (pwm_in),
        .pwm_out  (pwm_out),
        .flag     (brk_flag),
        .irq      (brk_irq),
        .run      (moe)
    );
endmodule

module mbrk_checker #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           brk_en,
    input logic           clk_fail,
    input logic           cmp_trip,
    input logic           sw_brk,
    input logic           moe_set,
    input logic           flag_clr,
    input logic           irq_en,
    input logic [NCH-1:0] idle_lvl,
    input logic [NCH-1:0] pwm_out,
    input logic           brk_flag,
    input logic           brk_irq,
    input logic           moe
);
    logic direct_evt;
    assign direct_evt = sw_brk || (brk_en && (clk_fail || cmp_trip));

    a_r1_idle_when_stopped: assert property (@(posedge clk) disable iff (rst)
        !moe |-> pwm_out == idle_lvl);

    a_r6_sw_forces_idle: assert property (@(posedge clk) disable iff (rst)
        sw_brk |-> pwm_out == idle_lvl);

    a_r9_event_stops_run: assert property (@(posedge clk) disable iff (rst)
        direct_evt |=> !moe);

    a_r9_set_loses_to_event: assert property (@(posedge clk) disable iff (rst)
        (direct_evt && moe_set) |=> !moe);

    a_r10_event_sets_flag: assert property (@(posedge clk) disable iff (rst)
        direct_evt |=> brk_flag);

    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (brk_flag && !flag_clr) |=> brk_flag);

    a_r11_no_irq_disabled: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !brk_irq);

    a_r12_reset_state: assert property (@(posedge clk)
        rst |=> (!brk_flag && !moe));
endmodule

bind mbrk_top mbrk_checker #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .brk_en   (brk_en),
    .clk_fail (clk_fail),
    .cmp_trip (cmp_trip),
    .sw_brk   (sw_brk),
    .moe_set  (moe_set),
    .flag_clr (flag_clr),
    .irq_en   (irq_en),
    .idle_lvl (idle_lvl),
    .pwm_out  (pwm_out),
    .brk_flag (brk_flag),
    .brk_irq  (brk_irq),
    .moe      (moe)
);

// File: tb/tb_mbrk_top.sv
module tb_mbrk_top;
    localparam int NCH = 4;
    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             brk_pin = 0, clk_fail = 0, cmp_trip = 0, sw_brk = 0;
    logic             brk_en = 0, brk_pol = 0, irq_en = 0, moe_set = 0, flag_clr = 0;
    logic [2:0]       flt_sel = '0;
    logic [DIV_W-1:0] samp_div = '0;
    logic [NCH-1:0]   idle_lvl = 4'b0110;
    logic [NCH-1:0]   pwm_in = 4'b1010;
    logic [NCH-1:0]   pwm_out;
    logic             brk_flag, brk_irq, moe;

    mbrk_top #(.NCH(NCH), .DIV_W(DIV_W)) dut (
        .clk(clk), .rst(rst), .brk_pin(brk_pin), .clk_fail(clk_fail),
        .cmp_trip(cmp_trip), .sw_brk(sw_brk), .brk_en(brk_en), .brk_pol(brk_pol),
        .flt_sel(flt_sel), .samp_div(samp_div), .irq_en(irq_en), .moe_set(moe_set),
        .flag_clr(flag_clr), .idle_lvl(idle_lvl), .pwm_in(pwm_in),
        .pwm_out(pwm_out), .brk_flag(brk_flag), .brk_irq(brk_irq), .moe(moe)
    );

    always #5 clk = ~clk;

    typedef struct {
        int             due;
        logic [NCH-1:0] o;
        logic           f;
        logic           i;
        logic           m;
        string          tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   total = 0;
    int   bad = 0;
    bit   finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare queued expectations whose cycle has arrived.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            exp_t e;
            e = q.pop_front();
            total++;
            if (pwm_out !== e.o || brk_flag !== e.f || brk_irq !== e.i || moe !== e.m) begin
                bad++;
                $display("FAIL %s: out=%b flag=%b irq=%b moe=%b expected out=%b flag=%b irq=%b moe=%b",
                         e.tag, pwm_out, brk_flag, brk_irq, moe, e.o, e.f, e.i, e.m);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Driver: queue an expectation for the current cycle, then advance one cycle.
    task automatic chk(input logic [NCH-1:0] o, input logic f, input logic i,
                       input logic m, input string tag);
        exp_t e;
        e.due = cyc; e.o = o; e.f = f; e.i = i; e.m = m; e.tag = tag;
        q.push_back(e);
        tick(1);
    endtask

    task automatic recover(input string tag);
        flag_clr = 1; moe_set = 1;
        tick(1);
        flag_clr = 0; moe_set = 0;
        chk(pwm_in, 0, 0, 1, tag);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst = 0;
        chk(idle_lvl, 0, 0, 0, "R12 reset state");
        recover("R9 set run latch");

        // R1: outputs follow pwm_in while running
        pwm_in = 4'b0101;
        chk(4'b0101, 0, 0, 1, "R1 pass-through");
        pwm_in = 4'b1010;

        // R2: clock failure
        brk_en = 1; clk_fail = 1;
        chk(idle_lvl, 0, 0, 1, "R2 same-cycle force");
        clk_fail = 0;
        chk(idle_lvl, 1, 0, 0, "R2 latched stop");
        recover("R9 restart after R2");
        brk_en = 0; clk_fail = 1;
        chk(pwm_in, 0, 0, 1, "R2 ignored when disabled");
        chk(pwm_in, 0, 0, 1, "R2 ignored next cycle");
        clk_fail = 0;

        // R3: comparator trip
        brk_en = 1; cmp_trip = 1;
        chk(idle_lvl, 0, 0, 1, "R3 same-cycle force");
        cmp_trip = 0;
        chk(idle_lvl, 1, 0, 0, "R3 latched stop");
        recover("R9 restart after R3");
        brk_en = 0; cmp_trip = 1;
        chk(pwm_in, 0, 0, 1, "R3 ignored when disabled");
        chk(pwm_in, 0, 0, 1, "R3 ignored next cycle");
        cmp_trip = 0;

        // R4: pin through synchronizer, filter bypassed
        brk_en = 1; brk_pol = 0; brk_pin = 1;
        chk(pwm_in, 0, 0, 1, "R4 no effect at edge 0");
        chk(pwm_in, 0, 0, 1, "R4 no effect at edge 1");
        chk(idle_lvl, 0, 0, 1, "R4 force after edge 2");
        chk(idle_lvl, 1, 0, 0, "R4 latched stop");
        brk_pin = 0;
        tick(3);
        recover("R9 restart after R4");

        // R5: polarity, enable and polarity written together
        brk_en = 0; brk_pin = 1;
        tick(4);
        brk_en = 1; brk_pol = 1;
        chk(pwm_in, 0, 0, 1, "R5 no spurious event");
        chk(pwm_in, 0, 0, 1, "R5 no spurious event later");
        brk_pin = 0;
        tick(2);
        chk(idle_lvl, 0, 0, 1, "R5 active-low pin");
        chk(idle_lvl, 1, 0, 0, "R5 latched stop");
        brk_pin = 1;
        tick(3);
        brk_en = 0; brk_pol = 0; brk_pin = 0;
        tick(3);
        brk_en = 1;
        recover("R9 restart after R5");

        // R6: software strobe with enable cleared
        brk_en = 0; sw_brk = 1;
        chk(idle_lvl, 0, 0, 1, "R6 sw force while disabled");
        sw_brk = 0;
        chk(idle_lvl, 1, 0, 0, "R6 sw latched stop");

        // R11 and R10 stickiness
        irq_en = 1;
        chk(idle_lvl, 1, 1, 0, "R11 irq when enabled");
        tick(5);
        chk(idle_lvl, 1, 1, 0, "R10 flag sticky");
        irq_en = 0;
        chk(idle_lvl, 1, 0, 0, "R11 irq masked");

        // R9/R10: set and clear lose to an active source
        brk_en = 1; clk_fail = 1;
        tick(1);
        moe_set = 1; flag_clr = 1;
        tick(1);
        moe_set = 0; flag_clr = 0;
        chk(idle_lvl, 1, 0, 0, "R9 set ignored during event, R10 event beats clear");
        clk_fail = 0;
        chk(idle_lvl, 1, 0, 0, "R9 stays stopped");
        flag_clr = 1;
        tick(1);
        flag_clr = 0;
        chk(idle_lvl, 0, 0, 0, "R10 flag cleared");
        idle_lvl = 4'b1001;
        chk(4'b1001, 0, 0, 0, "R1 idle levels per channel");
        idle_lvl = 4'b0110;
        recover("R9 restart after clear");

        // R7: filter N=4
        flt_sel = 3'd2; samp_div = '0;
        brk_pin = 1; tick(3); brk_pin = 0; tick(8);
        chk(pwm_in, 0, 0, 1, "R7 N=4 glitch of 3 rejected");
        brk_pin = 1;
        tick(5);
        chk(pwm_in, 0, 0, 1, "R7 N=4 not before 4 samples");
        chk(idle_lvl, 0, 0, 1, "R7 N=4 accepted");
        brk_pin = 0;
        tick(10);
        recover("R9 restart after N=4");

        // R7: filter N=16
        flt_sel = 3'd7;
        brk_pin = 1; tick(15); brk_pin = 0; tick(20);
        chk(pwm_in, 0, 0, 1, "R7 N=16 glitch of 15 rejected");
        brk_pin = 1;
        tick(17);
        chk(pwm_in, 0, 0, 1, "R7 N=16 not before 16 samples");
        chk(idle_lvl, 0, 0, 1, "R7 N=16 accepted");
        brk_pin = 0;
        tick(25);
        recover("R9 restart after N=16");

        // R8: sample divider with N=2
        flt_sel = 3'd1; samp_div = 8'd3;
        brk_pin = 1; tick(3); brk_pin = 0; tick(12);
        chk(pwm_in, 0, 0, 1, "R8 slow strobe rejects 3-cycle pulse");
        samp_div = '0;
        tick(2);
        brk_pin = 1;
        tick(3);
        brk_pin = 0;
        chk(pwm_in, 0, 0, 1, "R8 fast strobe one sample so far");
        chk(idle_lvl, 0, 0, 1, "R8 fast strobe accepts 3-cycle pulse");
        tick(8);
        recover("R9 final restart");

        tick(2);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule